// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small fully-associative line store placed between a first-level direct-mapped cache and that cache's refill path from the next memory level. When the direct-mapped cache misses, its controller presents the requested line address on the lookup port. All buffer entries compare their tags against it in the same cycle. If one matches, the line data is returned combinationally in that cycle. The miss then costs the controller one extra cycle instead of a full next-level access.

In victim mode, the controller presents, together with the lookup, the line that the direct-mapped cache is about to displace. On a buffer hit, that displaced line takes the place of the hit line at the next clock edge, so the two caches swap contents. On a full miss, the controller later pushes the displaced line through the insert port while the refill is fetched. A build parameter selects the alternative miss-cache mode instead. In that mode the refilled requested line is pushed through the insert port, and a hit leaves the buffer contents untouched. Replacement fills free entries first and otherwise evicts the least recently used entry.

Top module: `victim_buf`

## Requirements
- R1: A synchronous active-low reset invalidates every entry, so the first lookup after reset reports no hit.
- R2: In the cycle `lk_valid` is high, `lk_hit` is high exactly when a valid entry holds `lk_addr`, and `lk_data` then carries that entry's data; otherwise `lk_hit` is low and `lk_data` is zero, including whenever `lk_valid` is low.
- R3: In victim mode, a lookup hit replaces the hit entry at the next edge with the line on `lk_vic_addr`/`lk_vic_data` when `lk_vic_valid` is high, or invalidates the entry when it is low; the requested address then misses.
- R4: A lookup that misses changes no entry, and an insert presented in the same cycle as any lookup is dropped.
- R5: An insert of an address not held goes to the lowest-numbered invalid entry, or to the least recently used entry when all are valid.
- R6: An insert of an address already held overwrites that entry's data and creates no second copy.
- R7: Recency is updated by every lookup hit and every accepted insert, which make the touched entry the most recently used.
- R8: In miss-cache mode (`MODE` = VC_MISS), a lookup hit returns the data, keeps the entry unchanged, makes it most recently used, and ignores the `lk_vic_*` inputs.
- R9: No two valid entries ever hold the same address, so at most one entry matches a lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request after a main-cache miss |
| lk_addr | input | ADDR_W | Requested line address |
| lk_vic_valid | input | 1 | The displaced main-cache line is valid |
| lk_vic_addr | input | ADDR_W | Address of the displaced main-cache line |
| lk_vic_data | input | DATA_W | Data of the displaced main-cache line |
| lk_hit | output | 1 | Lookup found the line (same cycle) |
| lk_data | output | DATA_W | Line data on a hit, zero otherwise |
| ins_valid | input | 1 | Insert request |
| ins_addr | input | ADDR_W | Line address to insert |
| ins_data | input | DATA_W | Line data to insert |

## Verification
The bench drives two instances from the same stimulus. The first is a four-entry victim-mode instance and the second a two-entry miss-cache instance, both with 12-bit line addresses and 32-bit data. Most addresses come from a set of ten line addresses that share their low bits, as if they all alias to one direct-mapped set. This keeps both instances full, so eviction of the least recently used entry, overwrites of addresses already held and swaps happen on most vectors. The two-entry instance reaches full-buffer replacement after only two inserts. Running both modes side by side on identical traffic shows that only the mode parameter separates swap-on-hit from keep-on-hit.

// File: rtl/vc_pkg.sv
// Package: shared definitions for the victim buffer.
// Assumes: nothing beyond being compiled first.
package vc_pkg;
    // Which line the buffer captures.
    typedef enum logic {
        VC_VICTIM = 1'b0,   // keep the line displaced from the main cache
        VC_MISS   = 1'b1    // keep the requested (refilled) line
    } vc_mode_e;
endpackage

// File: rtl/vc_match.sv
// Module: vc_match
// Compares one address against every entry tag in parallel and encodes the
// matching entry number.
// Assumes: at most one valid entry matches, so an OR-encoder is exact.
module vc_match #(
    parameter int N     = 4,
    parameter int AW    = 26,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][AW-1:0] tag,
    input  logic [AW-1:0]        addr,
    output logic [N-1:0]         match,
    output logic                 any,
    output logic [IDX_W-1:0]     idx
);
    // One comparator per entry.
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid[g] && (tag[g] == addr);
    end

    assign any = |match;

    // OR-encode the one-hot match vector into an entry number.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/vc_lru.sv
// Module: vc_lru
// Keeps a recency rank per entry (0 = most recent, N-1 = least recent) and
// picks the entry a new line goes to: the lowest invalid entry, otherwise
// the least recently used one.
// Assumes: ranks form a permutation of 0..N-1, which reset establishes and
// every update preserves.
module vc_lru #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    touch,
    input  logic [IDX_W-1:0]        touch_idx,
    input  logic [N-1:0]            valid,
    output logic [N-1:0][IDX_W-1:0] age,
    output logic [IDX_W-1:0]        fill_idx
);
    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N - 1);

    logic [IDX_W-1:0] touched_age;

    // Rank currently held by the entry being touched.
    always_comb begin
        touched_age = '0;
        for (int i = 0; i < N; i++) begin
            if (touch_idx == IDX_W'(i)) touched_age = age[i];
        end
    end

    // Move the touched entry to rank 0 and age those that were more recent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) age[i] <= IDX_W'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (touch_idx == IDX_W'(i))
                    age[i] <= '0;
                else if (age[i] < touched_age)
                    age[i] <= age[i] + 1'b1;
            end
        end
    end

    // Choose the destination: lowest free entry first, else the oldest.
    always_comb begin
        logic found;
        found    = 1'b0;
        fill_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (age[i] == OLDEST) fill_idx = IDX_W'(i);
        end
        for (int i = 0; i < N; i++) begin
            if (!valid[i] && !found) begin
                fill_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/vc_store.sv
// Module: vc_store
// Entry storage: valid bits, line address tags and line data, with one
// write port.
// Assumes: w_idx is below N whenever we is high; only the valid bits need
// a reset, because tags and data are never read through an invalid entry.
module vc_store #(
    parameter int N     = 4,
    parameter int AW    = 26,
    parameter int DW    = 64,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [IDX_W-1:0]     w_idx,
    input  logic                 w_valid,
    input  logic [AW-1:0]        w_tag,
    input  logic [DW-1:0]        w_data,
    output logic [N-1:0]         valid,
    output logic [N-1:0][AW-1:0] tag,
    output logic [N-1:0][DW-1:0] data
);
    // Valid bits: cleared by reset, set or cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
        end else if (we) begin
            for (int i = 0; i < N; i++) begin
                if (w_idx == IDX_W'(i)) valid[i] <= w_valid;
            end
        end
    end

    // Tag and data payload of the written entry.
    always_ff @(posedge clk) begin
        if (we) begin
            for (int i = 0; i < N; i++) begin
                if (w_idx == IDX_W'(i)) begin
                    tag[i]  <= w_tag;
                    data[i] <= w_data;
                end
            end
        end
    end
endmodule

// File: rtl/victim_buf.sv
// Module: victim_buf (top)
// Small fully-associative buffer beside a direct-mapped cache. A lookup
// is answered in the same cycle. In victim mode a hit swaps the hit line
// with the displaced main-cache line at the next edge. In miss mode a hit
// only refreshes recency. Lines enter through the insert port, which yields
// to a lookup presented in the same cycle.
// Assumes: in victim mode the displaced line is never already held in the
// buffer (the two caches are exclusive); ENTRIES is between 1 and 8.
module victim_buf
    import vc_pkg::*;
#(
    parameter int       ENTRIES = 4,
    parameter int       ADDR_W  = 26,
    parameter int       DATA_W  = 64,
    parameter vc_mode_e MODE    = VC_VICTIM
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              lk_vic_valid,
    input  logic [ADDR_W-1:0] lk_vic_addr,
    input  logic [DATA_W-1:0] lk_vic_data,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              ins_valid,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [DATA_W-1:0] ins_data
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic [ENTRIES-1:0]              valid_q;
    logic [ENTRIES-1:0][ADDR_W-1:0]  tag_q;
    logic [ENTRIES-1:0][DATA_W-1:0]  data_q;
    logic [ENTRIES-1:0][IDX_W-1:0]   age_q;

    logic [ENTRIES-1:0] lk_match, ins_match;
    logic               lk_any, ins_any;
    logic [IDX_W-1:0]   hit_idx, ins_idx, fill_idx;

    logic               we, w_valid, touch;
    logic [IDX_W-1:0]   w_idx;
    logic [ADDR_W-1:0]  w_tag;
    logic [DATA_W-1:0]  w_data;

    vc_match #(.N(ENTRIES), .AW(ADDR_W), .IDX_W(IDX_W)) u_lk_match (
        .valid(valid_q), .tag(tag_q), .addr(lk_addr),
        .match(lk_match), .any(lk_any), .idx(hit_idx)
    );

    vc_match #(.N(ENTRIES), .AW(ADDR_W), .IDX_W(IDX_W)) u_ins_match (
        .valid(valid_q), .tag(tag_q), .addr(ins_addr),
        .match(ins_match), .any(ins_any), .idx(ins_idx)
    );

    vc_lru #(.N(ENTRIES), .IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .touch(touch), .touch_idx(w_idx),
        .valid(valid_q), .age(age_q), .fill_idx(fill_idx)
    );

    vc_store #(.N(ENTRIES), .AW(ADDR_W), .DW(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(we), .w_idx(w_idx), .w_valid(w_valid),
        .w_tag(w_tag), .w_data(w_data),
        .valid(valid_q), .tag(tag_q), .data(data_q)
    );

    // Same-cycle lookup answer.
    assign lk_hit  = lk_valid && lk_any;
    assign lk_data = lk_hit ? data_q[hit_idx] : '0;

    // Decide this cycle's write and recency update; a lookup has priority.
    always_comb begin
        we      = 1'b0;
        touch   = 1'b0;
        w_idx   = '0;
        w_valid = 1'b0;
        w_tag   = '0;
        w_data  = '0;
        if (lk_valid) begin
            if (lk_any) begin
                touch = 1'b1;
                w_idx = hit_idx;
                if (MODE == VC_VICTIM) begin
                    we      = 1'b1;
                    w_valid = lk_vic_valid;
                    w_tag   = lk_vic_addr;
                    w_data  = lk_vic_data;
                end
            end
        end else if (ins_valid) begin
            we      = 1'b1;
            touch   = 1'b1;
            w_idx   = ins_any ? ins_idx : fill_idx;
            w_valid = 1'b1;
            w_tag   = ins_addr;
            w_data  = ins_data;
        end
    end
endmodule

// File: rtl/vc_checker.sv
// Module: vc_checker
// Property checks for victim_buf, attached to every instance by bind.
// Assumes: it sees the top's internal match vector, entry state and ranks.
module vc_checker
    import vc_pkg::*;
#(
    parameter int       N     = 4,
    parameter int       AW    = 26,
    parameter int       IDX_W = 2,
    parameter vc_mode_e MODE  = VC_VICTIM
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lk_valid,
    input logic                    lk_hit,
    input logic                    lk_vic_valid,
    input logic [AW-1:0]           lk_vic_addr,
    input logic [IDX_W-1:0]        hit_idx,
    input logic [N-1:0]            lk_match,
    input logic [N-1:0]            valid,
    input logic [N-1:0][AW-1:0]    tag,
    input logic [N-1:0][IDX_W-1:0] age
);
    logic [N-1:0] rank_seen;
    logic         dup_tag;

    // Mark each rank value that some entry holds.
    always_comb begin
        rank_seen = '0;
        for (int r = 0; r < N; r++) begin
            for (int i = 0; i < N; i++) begin
                if (age[i] == IDX_W'(r)) rank_seen[r] = 1'b1;
            end
        end
    end

    // Flag two valid entries that hold the same address.
    always_comb begin
        dup_tag = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = i + 1; j < N; j++) begin
                if (valid[i] && valid[j] && tag[i] == tag[j]) dup_tag = 1'b1;
            end
        end
    end

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (valid == '0));

    a_r9_one_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    a_r9_distinct_tags: assert property (@(posedge clk) disable iff (!rst_n)
        !dup_tag);

    a_r4_miss_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !lk_hit) |=> ($stable(valid) && $stable(tag)));

    a_r7_rank_permutation: assert property (@(posedge clk) disable iff (!rst_n)
        &rank_seen);

    if (MODE == VC_VICTIM) begin : g_victim
        a_r3_swap_in: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_hit && lk_vic_valid) |=>
                (valid[$past(hit_idx)] && tag[$past(hit_idx)] == $past(lk_vic_addr)));
    end else begin : g_miss
        a_r8_hit_keeps_entry: assert property (@(posedge clk) disable iff (!rst_n)
            lk_hit |=> ($stable(valid) && $stable(tag)));
    end
endmodule

bind victim_buf vc_checker #(
    .N(ENTRIES), .AW(ADDR_W), .IDX_W(IDX_W), .MODE(MODE)
) u_vc_checker (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
    .lk_vic_valid(lk_vic_valid), .lk_vic_addr(lk_vic_addr),
    .hit_idx(hit_idx), .lk_match(lk_match), .valid(valid_q),
    .tag(tag_q), .age(age_q)
);

// File: tb/test_victim_buf.sv
// Bench: two instances (4-entry victim mode, 2-entry miss mode) share one
// stimulus stream; each is compared against its own bench-side model.
module test_victim_buf;
    import vc_pkg::*;

    localparam int PERIOD = 10;
    localparam int AW     = 12;
    localparam int DW     = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lv = 1'b0, vv = 1'b0, iv = 1'b0;
    logic [AW-1:0] la = '0, va = '0, ia = '0;
    logic [DW-1:0] vd = '0, id = '0;
    logic          hit0, hit1;
    logic [DW-1:0] dat0, dat1;

    int vectors = 0;
    int fails   = 0;

    always #(PERIOD/2) clk = ~clk;

    victim_buf #(.ENTRIES(4), .ADDR_W(AW), .DATA_W(DW), .MODE(VC_VICTIM)) i_victim_buf (
        .clk(clk), .rst_n(rst_n), .lk_valid(lv), .lk_addr(la),
        .lk_vic_valid(vv), .lk_vic_addr(va), .lk_vic_data(vd),
        .lk_hit(hit0), .lk_data(dat0),
        .ins_valid(iv), .ins_addr(ia), .ins_data(id)
    );

    victim_buf #(.ENTRIES(2), .ADDR_W(AW), .DATA_W(DW), .MODE(VC_MISS)) i_victim_buf_mc (
        .clk(clk), .rst_n(rst_n), .lk_valid(lv), .lk_addr(la),
        .lk_vic_valid(vv), .lk_vic_addr(va), .lk_vic_data(vd),
        .lk_hit(hit1), .lk_data(dat1),
        .ins_valid(iv), .ins_addr(ia), .ins_data(id)
    );

    // Reference model: unit 0 is victim mode, unit 1 is miss mode.
    bit            m_v [2][4];
    logic [AW-1:0] m_a [2][4];
    logic [DW-1:0] m_d [2][4];
    int            m_ord [2][4];   // entry numbers, most recent first
    int            m_n [2] = '{4, 2};

    function automatic void m_reset();
        for (int u = 0; u < 2; u++)
            for (int j = 0; j < 4; j++) begin
                m_v[u][j] = 1'b0;
                m_ord[u][j] = j;
            end
    endfunction

    function automatic int m_find(int u, logic [AW-1:0] a);
        for (int j = 0; j < m_n[u]; j++)
            if (m_v[u][j] && m_a[u][j] == a) return j;
        return -1;
    endfunction

    function automatic void m_touch(int u, int k);
        int p = 0;
        for (int j = 0; j < m_n[u]; j++) if (m_ord[u][j] == k) p = j;
        for (int j = p; j > 0; j--) m_ord[u][j] = m_ord[u][j-1];
        m_ord[u][0] = k;
    endfunction

    function automatic void m_update(int u);
        int k;
        if (lv) begin
            k = m_find(u, la);
            if (k >= 0) begin
                if (u == 0) begin
                    m_v[u][k] = vv; m_a[u][k] = va; m_d[u][k] = vd;
                end
                m_touch(u, k);
            end
        end else if (iv) begin
            k = m_find(u, ia);
            if (k < 0) begin
                for (int j = m_n[u] - 1; j >= 0; j--) if (!m_v[u][j]) k = j;
                if (k < 0) k = m_ord[u][m_n[u] - 1];
            end
            m_v[u][k] = 1'b1; m_a[u][k] = ia; m_d[u][k] = id;
            m_touch(u, k);
        end
    endfunction

    // Compare both units, advance the model, then move to the next negedge.
    task automatic apply(input string req);
        #(PERIOD/4);
        for (int u = 0; u < 2; u++) begin
            int            k = lv ? m_find(u, la) : -1;
            logic          eh = (k >= 0);
            logic [DW-1:0] ed = eh ? m_d[u][k] : '0;
            logic          ah = (u == 0) ? hit0 : hit1;
            logic [DW-1:0] ad = (u == 0) ? dat0 : dat1;
            string         r = req;
            if (r == "") r = eh ? ((u == 0) ? "R3" : "R8") : "R2";
            vectors++;
            if (ah !== eh || ad !== ed) begin
                fails++;
                $display("FAIL %s unit%0d addr=%h: actual hit=%b data=%h expected hit=%b data=%h",
                         r, u, la, ah, ad, eh, ed);
            end
        end
        for (int u = 0; u < 2; u++) m_update(u);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic l, input logic [AW-1:0] a, input logic v,
                         input logic [AW-1:0] vaddr, input logic [DW-1:0] vdata,
                         input logic i, input logic [AW-1:0] iaddr,
                         input logic [DW-1:0] idata, input string req);
        lv = l; la = a; vv = v; va = vaddr; vd = vdata;
        iv = i; ia = iaddr; id = idata;
        apply(req);
    endtask

    function automatic logic [AW-1:0] alias_addr(int t);
        return AW'((t << 4) | 5);
    endfunction

    // Watchdog: a hung run is counted as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset.
        drive(1, alias_addr(1), 0, '0, '0, 0, '0, '0, "R1");
        // R5: fill free entries, then overflow the 2-entry unit.
        for (int t = 1; t <= 4; t++)
            drive(0, '0, 0, '0, '0, 1, alias_addr(t), 32'h1000 + t, "R5");
        for (int t = 1; t <= 4; t++)
            drive(1, alias_addr(t), 0, '0, '0, 0, '0, '0, "R5");
        // R6 / R9: rewrite a held address, only the newest data remains.
        drive(0, '0, 0, '0, '0, 1, alias_addr(2), 32'hAAAA0002, "R6");
        drive(0, '0, 0, '0, '0, 1, alias_addr(2), 32'hBBBB0002, "R6");
        drive(1, alias_addr(2), 1, 12'h805, 32'h5555, 0, '0, '0, "R9");
        // R3: swapped-in line hits, swapped-out line misses.
        drive(1, alias_addr(2), 0, '0, '0, 0, '0, '0, "R3");
        drive(1, 12'h805, 1, 12'h815, 32'h6666, 0, '0, '0, "R3");
        drive(1, 12'h815, 0, '0, '0, 0, '0, '0, "R3");
        // R4: an insert beside a lookup is dropped.
        drive(1, 12'h0F5, 0, '0, '0, 1, 12'h0E5, 32'h7777, "R4");
        drive(1, 12'h0E5, 0, '0, '0, 0, '0, '0, "R4");
        // R7: refresh recency by inserts, then overflow and probe.
        for (int t = 5; t <= 9; t++)
            drive(0, '0, 0, '0, '0, 1, alias_addr(t), 32'h2000 + t, "R7");
        drive(0, '0, 0, '0, '0, 1, alias_addr(6), 32'h3006, "R7");
        drive(0, '0, 0, '0, '0, 1, alias_addr(3), 32'h3003, "R7");
        for (int t = 3; t <= 9; t++)
            drive(1, alias_addr(t), 0, '0, '0, 0, '0, '0, "R7");
        // R8: miss-mode hit keeps the entry; a repeat lookup hits again.
        drive(0, '0, 0, '0, '0, 1, alias_addr(0), 32'h4000, "R8");
        drive(1, alias_addr(0), 1, 12'h825, 32'h4444, 0, '0, '0, "R8");
        drive(1, alias_addr(0), 0, '0, '0, 0, '0, '0, "R8");
        // R2: no answer without a lookup request.
        drive(0, alias_addr(0), 0, '0, '0, 0, '0, '0, "R2");

        // Constrained random traffic on the aliasing set.
        void'($urandom(32'd20240611));
        for (int n = 0; n < 3000; n++) begin
            logic          l = ($urandom % 2) == 0;
            logic [AW-1:0] a = alias_addr($urandom % 10);
            logic [AW-1:0] v;
            do v = alias_addr($urandom % 10);
            while (v == a || m_find(0, v) >= 0);
            drive(l, a, ($urandom % 10) < 7, v, $urandom,
                  ($urandom % 10) < 4, alias_addr($urandom % 10), $urandom, "");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule